// File: doc/BRIEF.md
# Merging Store Buffer

This block sits between a write-through data cache and the next memory level. Each cycle the processor may present one store: a 64-bit data word, a word address and a byte-enable mask. The buffer holds a small number of line-sized slots. Each slot has a line address, the line's data and one enable bit per byte. A store whose line already sits in a valid slot is folded into that slot. Any other store takes the next free slot. As soon as the buffer accepts a store, that store is finished from the processor's point of view.

Slots leave for memory in the order they were allocated, one line per transfer. Each transfer carries the line address, the full line of data with unwritten bytes forced to zero, a per-byte mask and a per-word mask. The oldest slot counts as draining from the moment it becomes oldest, so it never takes a merge. A store aimed at that line opens a fresh slot instead. When every slot is occupied and no mergeable slot matches, the store is held off by deasserting ready.

Top module: `merge_wbuf`

## Requirements
- R1: After reset, `st_ready` is 1, `dr_valid` is 0 and the buffer is empty.
- R2: With fewer than `ENTRIES` slots occupied, any store is accepted in the cycle it is presented. A store that matches no mergeable slot is written into a new slot.
- R3: A store whose line address (`st_addr[ADDR_W-1:2]` for four words per line) equals that of a valid slot other than the oldest is merged into that slot. No new slot is used.
- R4: Within a slot, each byte holds the value from the latest accepted store that enabled it. Word `st_addr[1:0]`, byte lane k of the store maps to line byte `word*8+k`.
- R5: When all slots are occupied and no slot other than the oldest matches, `st_ready` is 0 and the store is not taken. A match on a non-oldest slot is still accepted while the buffer is full.
- R6: Slots drain in allocation order. `dr_valid` rises one cycle after the oldest slot exists and no transfer is pending. `dr_addr` gives that slot's line address.
- R7: `dr_bmask` bit n marks line byte n as written. `dr_wmask` bit w is the OR of the eight byte bits of word w. `dr_data` is zero in every unwritten byte.
- R8: The oldest occupied slot never takes a merge. A store to its line opens a new slot. This includes a store presented in the cycle its transfer completes.
- R9: While `dr_valid` is 1 and `dr_ready` is 0, all drain outputs hold their values.
- R10: After a handshake (`dr_valid` and `dr_ready` both 1), the slot is freed and `dr_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store presented |
| st_ready | output | 1 | Store accepted this cycle when high |
| st_addr | input | ADDR_W | Word address of the store |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Byte enables of the store |
| dr_valid | output | 1 | Line transfer pending |
| dr_ready | input | 1 | Memory takes the transfer |
| dr_addr | output | ADDR_W-log2(WORDS) | Line address of the transfer |
| dr_data | output | WORDS*DATA_W | Line data, unwritten bytes zero |
| dr_wmask | output | WORDS | Words holding written bytes |
| dr_bmask | output | WORDS*DATA_W/8 | Written bytes |

## Verification
The assertions assume that every presented store enables at least one byte. From that assumption they derive that each transfer carries a non-empty word mask. They also assume that the memory side may hold `dr_ready` low for any number of cycles, but never pulls back a transfer once it has taken it. The stimulus always draws byte enables from non-zero values. It spreads addresses over only four lines so that matches, merges into non-oldest slots and stalls on a full buffer come up often. It toggles `dr_ready` freely, including long low stretches that pin the buffer full.

// File: rtl/merge_wbuf_pkg.sv
package merge_wbuf_pkg;

  // Circular slot pointer advance for any slot count.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned n);
    return (p + 1 == n) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/merge_wbuf_cam.sv
module merge_wbuf_cam #(
  parameter int unsigned N     = 4,
  parameter int unsigned TAG_W = 30,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     elig,
  input  logic [TAG_W-1:0] tags [N],
  input  logic [TAG_W-1:0] key,
  output logic [N-1:0]     hit_vec,
  output logic             hit_any,
  output logic [IDX_W-1:0] hit_idx
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = elig[i] && (tags[i] == key);
  end

  assign hit_any = |hit_vec;

  // Slots hold distinct lines, so at most one bit is set: OR of indices.
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/merge_wbuf_ram.sv
module merge_wbuf_ram #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 256,
  localparam int unsigned NBYTE = WIDTH / 8,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [NBYTE-1:0] wbe,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Byte-lane write enables, registered read port.
  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && wbe[b]) mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned WORDS   = 4,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned BYTES     = DATA_W / 8,
  localparam int unsigned LBYTES    = WORDS * BYTES,
  localparam int unsigned LINE_BITS = WORDS * DATA_W,
  localparam int unsigned WOFF_W    = $clog2(WORDS),
  localparam int unsigned LINE_W    = ADDR_W - WOFF_W,
  localparam int unsigned IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned CNT_W     = $clog2(ENTRIES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 st_valid,
  output logic                 st_ready,
  input  logic [ADDR_W-1:0]    st_addr,
  input  logic [DATA_W-1:0]    st_data,
  input  logic [BYTES-1:0]     st_be,
  output logic                 dr_valid,
  input  logic                 dr_ready,
  output logic [LINE_W-1:0]    dr_addr,
  output logic [LINE_BITS-1:0] dr_data,
  output logic [WORDS-1:0]     dr_wmask,
  output logic [LBYTES-1:0]    dr_bmask
);
  import merge_wbuf_pkg::*;

  // Slot state
  logic [ENTRIES-1:0] valid_q;
  logic [LINE_W-1:0]  tag_q [ENTRIES];
  logic [LBYTES-1:0]  bm_q  [ENTRIES];
  logic [IDX_W-1:0]   head_q, tail_q;
  logic [CNT_W-1:0]   count_q;

  // Drain output registers
  logic              dr_valid_q;
  logic [LINE_W-1:0] dr_addr_q;
  logic [LBYTES-1:0] dr_bm_q;
  logic [WORDS-1:0]  dr_wm_q;

  // Store path decode
  logic [WOFF_W-1:0]    wsel;
  logic [LINE_W-1:0]    sline;
  logic [LBYTES-1:0]    line_be;
  logic [LINE_BITS-1:0] line_data;

  assign wsel      = st_addr[WOFF_W-1:0];
  assign sline     = st_addr[ADDR_W-1:WOFF_W];
  assign line_be   = LBYTES'(st_be) << (wsel * BYTES);
  assign line_data = {WORDS{st_data}};

  // Oldest slot is draining and excluded from matching.
  logic [ENTRIES-1:0] elig, hit_vec;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      elig[i] = valid_q[i] && (IDX_W'(i) != head_q);
    end
  end

  merge_wbuf_cam #(.N(ENTRIES), .TAG_W(LINE_W)) u_cam (
    .elig    (elig),
    .tags    (tag_q),
    .key     (sline),
    .hit_vec (hit_vec),
    .hit_any (hit_any),
    .hit_idx (hit_idx)
  );

  logic accept, alloc, load, fire;
  logic [IDX_W-1:0] widx;

  assign st_ready = hit_any || (count_q != CNT_W'(ENTRIES));
  assign accept   = st_valid && st_ready;
  assign alloc    = accept && !hit_any;
  assign widx     = hit_any ? hit_idx : tail_q;
  assign load     = !dr_valid_q && valid_q[head_q];
  assign fire     = dr_valid_q && dr_ready;

  logic [LINE_BITS-1:0] rd_data;

  merge_wbuf_ram #(.DEPTH(ENTRIES), .WIDTH(LINE_BITS)) u_ram (
    .clk   (clk),
    .we    (accept),
    .waddr (widx),
    .wbe   (line_be),
    .wdata (line_data),
    .re    (load),
    .raddr (head_q),
    .rdata (rd_data)
  );

  logic [WORDS-1:0] head_wmask;
  always_comb begin
    for (int w = 0; w < WORDS; w++) begin
      head_wmask[w] = |bm_q[head_q][w*BYTES +: BYTES];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q    <= '0;
      head_q     <= '0;
      tail_q     <= '0;
      count_q    <= '0;
      dr_valid_q <= 1'b0;
      dr_addr_q  <= '0;
      dr_bm_q    <= '0;
      dr_wm_q    <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        bm_q[i]  <= '0;
      end
    end else begin
      if (accept) begin
        if (hit_any) begin
          bm_q[hit_idx] <= bm_q[hit_idx] | line_be;
        end else begin
          tag_q[tail_q]   <= sline;
          bm_q[tail_q]    <= line_be;
          valid_q[tail_q] <= 1'b1;
          tail_q          <= IDX_W'(wrap_inc(tail_q, ENTRIES));
        end
      end
      if (fire) begin
        valid_q[head_q] <= 1'b0;
        head_q          <= IDX_W'(wrap_inc(head_q, ENTRIES));
        dr_valid_q      <= 1'b0;
      end
      if (load) begin
        dr_valid_q <= 1'b1;
        dr_addr_q  <= tag_q[head_q];
        dr_bm_q    <= bm_q[head_q];
        dr_wm_q    <= head_wmask;
      end
      count_q <= count_q + CNT_W'(alloc) - CNT_W'(fire);
    end
  end

  logic [LINE_BITS-1:0] bit_mask;
  always_comb begin
    for (int b = 0; b < LBYTES; b++) bit_mask[b*8 +: 8] = {8{dr_bm_q[b]}};
  end

  assign dr_valid = dr_valid_q;
  assign dr_addr  = dr_addr_q;
  assign dr_bmask = dr_bm_q;
  assign dr_wmask = dr_wm_q;
  assign dr_data  = rd_data & bit_mask;

  // Input assumption: every store writes at least one byte (R2)
  assert_be_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> (st_be != '0));

  // A line lives in at most one mergeable slot (R3)
  assert_one_hit_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // Occupancy never exceeds the slot count (R5)
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(ENTRIES));

  // Every transfer names at least one written word (R7)
  assert_wmask_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    dr_valid |-> (dr_wmask != '0));

  // Pending transfer holds its content (R9)
  assert_drain_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) &&
                                 $stable(dr_bmask) && $stable(dr_data)));

  // Handshake frees the output for at least a cycle (R10)
  assert_drain_gap_R10: assert property (@(posedge clk) disable iff (rst)
    (dr_valid && dr_ready) |=> !dr_valid);

endmodule

// File: tb/tb_merge_wbuf.sv
`timescale 1ns/1ps
module tb_merge_wbuf;
  localparam int ENT = 4;
  localparam int LBITS = 256;

  logic clk = 1'b0;
  logic rst;
  logic st_valid, st_ready, dr_valid, dr_ready;
  logic [31:0]  st_addr;
  logic [63:0]  st_data;
  logic [7:0]   st_be;
  logic [29:0]  dr_addr;
  logic [255:0] dr_data;
  logic [3:0]   dr_wmask;
  logic [31:0]  dr_bmask;

  always #4 clk = ~clk;

  merge_wbuf dut (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
    .dr_data(dr_data), .dr_wmask(dr_wmask), .dr_bmask(dr_bmask)
  );

  typedef struct packed {
    logic [29:0]  line;
    logic [255:0] data;
    logic [31:0]  m;
  } slot_t;

  slot_t q[$];
  logic         m_v;
  logic [29:0]  m_line;
  logic [255:0] m_data;
  logic [31:0]  m_m;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h", req, tag, what, act, exp);
    end
  endtask

  function automatic int find_hit(input logic [29:0] ln);
    int h = -1;
    for (int i = 1; i < q.size(); i++) if (q[i].line == ln) h = i;
    return h;
  endfunction

  function automatic logic [3:0] wm_of(input logic [31:0] m);
    logic [3:0] r;
    for (int w = 0; w < 4; w++) r[w] = |m[w*8 +: 8];
    return r;
  endfunction

  // Compare now, then advance the model by one clock, then wait.
  task automatic step();
    int  h;
    bit  er, fire, load;
    slot_t e;
    #1;
    h  = find_hit(st_addr[31:2]);
    er = (h >= 0) || (q.size() < ENT);
    chk(st_ready === er, (q.size() == ENT) ? "R5" : "R2", "st_ready", 256'(st_ready), 256'(er));
    chk(dr_valid === m_v, "R6", "dr_valid", 256'(dr_valid), 256'(m_v));
    if (m_v) begin
      chk(dr_addr === m_line, "R6", "dr_addr", 256'(dr_addr), 256'(m_line));
      chk(dr_data === m_data, "R4", "dr_data", dr_data, m_data);
      chk(dr_bmask === m_m, "R7", "dr_bmask", 256'(dr_bmask), 256'(m_m));
      chk(dr_wmask === wm_of(m_m), "R7", "dr_wmask", 256'(dr_wmask), 256'(wm_of(m_m)));
    end
    fire = m_v && dr_ready;
    load = !m_v && (q.size() > 0);
    if (load) begin
      m_v = 1'b1; m_line = q[0].line; m_data = q[0].data; m_m = q[0].m;
    end
    if (st_valid && er) begin
      if (h >= 0) e = q[h];
      else begin e.line = st_addr[31:2]; e.data = '0; e.m = '0; end
      for (int b = 0; b < 8; b++) begin
        if (st_be[b]) begin
          e.data[(st_addr[1:0]*8 + b)*8 +: 8] = st_data[b*8 +: 8];
          e.m[st_addr[1:0]*8 + b] = 1'b1;
        end
      end
      if (h >= 0) q[h] = e; else q.push_back(e);
    end
    if (fire) begin
      void'(q.pop_front());
      m_v = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic put(input logic [29:0] ln, input logic [1:0] w,
                     input logic [7:0] be, input logic [63:0] d);
    st_valid = 1'b1; st_addr = {ln, w}; st_be = be; st_data = d;
  endtask

  task automatic idle();
    st_valid = 1'b0; st_addr = '0; st_be = 8'h01; st_data = '0;
  endtask

  logic [29:0] pool [4];

  initial begin
    pool[0] = 30'h0000_0005; pool[1] = 30'h0000_0006;
    pool[2] = 30'h3FFF_FFFF; pool[3] = 30'h0123_4567;
    rst = 1'b1; dr_ready = 1'b0; idle();
    q.delete(); m_v = 1'b0; m_line = '0; m_data = '0; m_m = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1"; step();

    // Fill with the memory side stalled
    tag = "R2"; put(pool[0], 2'd0, 8'hFF, 64'h1111_2222_3333_4444); step();
    tag = "R8"; put(pool[0], 2'd1, 8'hFF, 64'hAAAA_BBBB_CCCC_DDDD); step();
    tag = "R3"; put(pool[1], 2'd2, 8'h0F, 64'h0000_0000_1234_5678); step();
    put(pool[1], 2'd2, 8'hF0, 64'h9ABC_DEF0_0000_0000); step();
    tag = "R4"; put(pool[1], 2'd2, 8'h3C, 64'h5555_5555_5555_5555); step();
    put(pool[1], 2'd3, 8'h80, 64'hEE00_0000_0000_0000); step();
    tag = "R2"; put(pool[2], 2'd3, 8'h01, 64'h0000_0000_0000_00C3); step();
    put(pool[3], 2'd1, 8'hFF, 64'h0F0F_0F0F_0F0F_0F0F); step();
    tag = "R5"; put(pool[1], 2'd0, 8'h01, 64'h77); step();
    put(pool[2], 2'd0, 8'hFF, 64'hDEAD_BEEF_0000_0001); step();
    tag = "R8"; put(pool[0], 2'd3, 8'hFF, 64'h1); step();
    tag = "R9"; step(); step();
    tag = "R10"; dr_ready = 1'b1; idle();
    repeat (12) step();

    // Same-line store in the cycle the oldest slot completes
    tag = "R8"; dr_ready = 1'b0;
    put(pool[2], 2'd0, 8'h03, 64'hABCD); step();
    idle(); step(); step();
    dr_ready = 1'b1; put(pool[2], 2'd1, 8'hFF, 64'h4242); step();
    idle(); dr_ready = 1'b1; repeat (8) step();

    // Random traffic
    tag = "R6";
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] be;
      be = 8'($urandom);
      if (be == 8'h00) be = 8'h10;
      if (($urandom % 10) < 6)
        put(pool[$urandom % 4], 2'($urandom), be, {$urandom, $urandom});
      else idle();
      dr_ready = (($urandom % 8) < ((n / 500) % 2 == 0 ? 2 : 6));
      step();
    end
    idle(); dr_ready = 1'b1; repeat (12) step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule